// File: doc/BRIEF.md
# PMP Region Bound Decoder

This block turns the stored protection-entry state of a memory protection unit into plain byte-address windows. For every entry it reads the two-bit match-mode field from the entry's configuration byte, the entry's own address register and the address register of the entry just below it. From these it derives an inclusive start and end byte address. The access checker downstream then only needs two magnitude compares per entry.

Address registers hold a byte address with its two least significant bits dropped, so each bound is two bits wider than a register. The supported modes are disabled, top-of-range, naturally aligned four-byte, and naturally aligned power-of-two. In the power-of-two mode the run of trailing ones in the register selects the region size. The block also reports how many entries are enabled. All outputs are registered, so a rule change shows up one clock after it is presented on the inputs.

Top module: `pmp_bound_decoder`

## Requirements
- R1: While reset is high, every start bound, every end bound and the active count are registered as zero.
- R2: The match mode of entry i sits in bits [4:3] of its configuration byte, which occupies cfg_i[8i+7:8i]. Mode 0 (disabled) yields start 0 and an all-ones end of ADDR_W+2 bits.
- R3: Mode 1 (top-of-range) yields start = previous register shifted left by 2 and end = own register shifted left by 2, minus 1, modulo 2^(ADDR_W+2). Entry 0 uses zero as its previous register.
- R4: In mode 1, when the computed start is greater than the computed end, both bounds become zero.
- R5: Mode 2 (four-byte) yields start = own register shifted left by 2 and end = start + 3.
- R6: Mode 3 (power-of-two) uses k, the number of trailing ones in the register. The region is 2^(k+3) bytes, aligned to its size, and contains the register shifted left by 2. A register of all ones covers the whole space, with start 0 and end all ones.
- R7: The active count equals the number of entries whose mode is not 0.
- R8: Configuration bits [7:5] and [2:0] have no effect on any bound or on the count.
- R9: Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | NUM_ENTRIES*8 | Configuration byte per entry, entry i at [8i+7:8i] |
| addr_i | input | NUM_ENTRIES*ADDR_W | Address register per entry, entry i at [ADDR_W*i +: ADDR_W] |
| lo_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive start byte address per entry |
| hi_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive end byte address per entry |
| count_o | output | $clog2(NUM_ENTRIES+1) | Number of enabled entries |

## Verification
The assertions check shape properties on every cycle against the mode sampled one edge earlier. A disabled entry spans the full space, and start never exceeds end. A four-byte entry spans exactly three above its start. A power-of-two span is an aligned mask of at least eight bytes. The count matches the population of enabled modes. The assertions cannot tell whether a window sits at the right place. Exact start and end values, the zero-previous rule for entry 0, the choice between a collapsed and a legal top-of-range window, and the indifference to the other configuration bits are shown only by the bench, which compares each output against its own model.

// File: rtl/pmpb_pkg.sv
package pmpb_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    localparam int CFG_BYTE_W = 8;
    localparam int MODE_LSB   = 3;

    function automatic match_mode_e mode_of(input logic [CFG_BYTE_W-1:0] cfg_byte);
        return match_mode_e'(cfg_byte[MODE_LSB +: 2]);
    endfunction

    function automatic logic is_enabled(input match_mode_e m);
        return m != MATCH_OFF;
    endfunction

endpackage

// File: rtl/pmpb_entry_dec.sv
module pmpb_entry_dec
    import pmpb_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int BW = ADDR_W + 2
) (
    input  match_mode_e       mode,
    input  logic [ADDR_W-1:0] self_addr,
    input  logic [ADDR_W-1:0] below_addr,
    output logic [BW-1:0]     lo,
    output logic [BW-1:0]     hi
);

    logic [BW-1:0] self_byte;
    logic [BW-1:0] below_byte;
    logic [BW-1:0] tor_lo, tor_hi;
    logic [BW-1:0] pow_a, pow_inc;

    always_comb begin
        self_byte  = {self_addr, 2'b00};
        below_byte = {below_addr, 2'b00};
        tor_lo     = below_byte;
        tor_hi     = self_byte - BW'(1);
        pow_a      = {self_addr, 2'b11};
        pow_inc    = pow_a + BW'(1);
    end

    always_comb begin
        lo = '0;
        hi = '0;
        unique case (mode)
            MATCH_OFF: begin
                lo = '0;
                hi = '1;
            end
            MATCH_TOR: begin
                if (tor_lo > tor_hi) begin
                    lo = '0;
                    hi = '0;
                end else begin
                    lo = tor_lo;
                    hi = tor_hi;
                end
            end
            MATCH_NA4: begin
                lo = self_byte;
                hi = self_byte + BW'(3);
            end
            MATCH_NAPOT: begin
                lo = pow_a & pow_inc;
                hi = pow_a | pow_inc;
            end
            default: begin
                lo = '0;
                hi = '0;
            end
        endcase
    end

endmodule

// File: rtl/pmpb_active_cnt.sv
module pmpb_active_cnt #(
    parameter int NUM_ENTRIES = 8,
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [NUM_ENTRIES-1:0] enabled,
    output logic [CNT_W-1:0]       count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            count = count + CNT_W'(enabled[i]);
        end
    end

endmodule

// File: rtl/pmp_bound_decoder.sv
module pmp_bound_decoder
    import pmpb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    localparam int BW    = ADDR_W + 2,
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_ENTRIES*8-1:0]      cfg_i,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] addr_i,
    output logic [NUM_ENTRIES*BW-1:0]     lo_o,
    output logic [NUM_ENTRIES*BW-1:0]     hi_o,
    output logic [CNT_W-1:0]              count_o
);

    match_mode_e      mode_w  [NUM_ENTRIES];
    logic [BW-1:0]    lo_w    [NUM_ENTRIES];
    logic [BW-1:0]    hi_w    [NUM_ENTRIES];
    logic [BW-1:0]    lo_q    [NUM_ENTRIES];
    logic [BW-1:0]    hi_q    [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] enabled_w;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] count_q;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            logic [ADDR_W-1:0] below;
            assign mode_w[g]    = mode_of(cfg_i[g*8 +: 8]);
            assign enabled_w[g] = is_enabled(mode_w[g]);

            if (g == 0) begin : g_first
                assign below = '0;
            end else begin : g_rest
                assign below = addr_i[(g-1)*ADDR_W +: ADDR_W];
            end

            pmpb_entry_dec #(.ADDR_W(ADDR_W)) u_dec (
                .mode       (mode_w[g]),
                .self_addr  (addr_i[g*ADDR_W +: ADDR_W]),
                .below_addr (below),
                .lo         (lo_w[g]),
                .hi         (hi_w[g])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q[g] <= '0;
                    hi_q[g] <= '0;
                end else begin
                    lo_q[g] <= lo_w[g];
                    hi_q[g] <= hi_w[g];
                end
            end

            assign lo_o[g*BW +: BW] = lo_q[g];
            assign hi_o[g*BW +: BW] = hi_q[g];

            assert_off_full_R2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_i[g*8+4 -: 2]) == 2'd0)
                |-> (lo_q[g] == '0 && hi_q[g] == '1));

            assert_order_R4: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (lo_q[g] <= hi_q[g]));

            assert_na4_span_R5: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_i[g*8+4 -: 2]) == 2'd2)
                |-> ((hi_q[g] - lo_q[g]) == BW'(3)));

            assert_napot_pow2_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cfg_i[g*8+4 -: 2]) == 2'd3)
                |-> ((((hi_q[g] - lo_q[g]) & (hi_q[g] - lo_q[g] + BW'(1))) == '0)
                     && ((hi_q[g] - lo_q[g]) >= BW'(7))
                     && ((lo_q[g] & (hi_q[g] - lo_q[g])) == '0)));
        end
    endgenerate

    pmpb_active_cnt #(.NUM_ENTRIES(NUM_ENTRIES)) u_cnt (
        .enabled (enabled_w),
        .count   (count_w)
    );

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_w;
    end

    assign count_o = count_q;

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> (count_q == '0 && lo_q[0] == '0 && hi_q[0] == '0));

    assert_count_match_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (32'(count_q) == $past($countones(enabled_w))));

endmodule

// File: tb/sim_pmp_bound_decoder.sv
module sim_pmp_bound_decoder;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int BW = AW + 2;
    localparam int CW = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*8-1:0]    cfg = '0;
    logic [N*AW-1:0]   addr = '0;
    logic [N*BW-1:0]   lo, hi;
    logic [CW-1:0]     count;
    int                total = 0;
    int                fails = 0;
    logic [N*BW-1:0]   lo_keep, hi_keep;
    logic [CW-1:0]     cnt_keep;

    always #10 clk = ~clk;

    pmp_bound_decoder #(.NUM_ENTRIES(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_i(cfg), .addr_i(addr),
        .lo_o(lo), .hi_o(hi), .count_o(count)
    );

    task automatic model(input logic [1:0] m, input logic [AW-1:0] a,
                         input logic [AW-1:0] p,
                         output logic [BW-1:0] elo, output logic [BW-1:0] ehi);
        logic [BW-1:0] mask;
        int k;
        case (m)
            2'd0: begin elo = '0; ehi = '1; end
            2'd1: begin
                elo = {p, 2'b00};
                ehi = {a, 2'b00} - BW'(1);
                if (elo > ehi) begin elo = '0; ehi = '0; end
            end
            2'd2: begin elo = {a, 2'b00}; ehi = elo + BW'(3); end
            default: begin
                k = 0;
                while (k < AW && a[k]) k++;
                if (k == AW) begin
                    elo = '0; ehi = '1;
                end else begin
                    mask = (BW'(1) << (k + 3)) - BW'(1);
                    elo = {a, 2'b00} & ~mask;
                    ehi = elo | mask;
                end
            end
        endcase
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_and_check(input string req);
        logic [BW-1:0] elo, ehi;
        logic [AW-1:0] prev;
        int ecnt;
        @(negedge clk);
        @(posedge clk);
        #5;
        ecnt = 0;
        for (int i = 0; i < N; i++) begin
            prev = (i == 0) ? '0 : addr[(i-1)*AW +: AW];
            model(cfg[i*8+3 +: 2], addr[i*AW +: AW], prev, elo, ehi);
            if (cfg[i*8+3 +: 2] != 2'd0) ecnt++;
            check({req, " lo"}, 64'(lo[i*BW +: BW]), 64'(elo));
            check({req, " hi"}, 64'(hi[i*BW +: BW]), 64'(ehi));
        end
        check({req, " R7 count"}, 64'(count), 64'(ecnt));
    endtask

    task automatic set_entry(input int i, input logic [7:0] c, input logic [AW-1:0] a);
        cfg[i*8 +: 8]   = c;
        addr[i*AW +: AW] = a;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        total++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        // R1: reset state, inputs busy
        for (int i = 0; i < N; i++) set_entry(i, 8'h18, 32'h1234_5678 + i);
        @(posedge clk); @(posedge clk); #5;
        for (int i = 0; i < N; i++) begin
            check("R1 lo", 64'(lo[i*BW +: BW]), 64'd0);
            check("R1 hi", 64'(hi[i*BW +: BW]), 64'd0);
        end
        check("R1 count", 64'(count), 64'd0);
        @(negedge clk); rst = 1'b0;

        // R2 all off
        cfg = '0;
        apply_and_check("R2 off");

        // R3 TOR chain, entry 0 uses zero below
        for (int i = 0; i < N; i++) set_entry(i, 8'h08, 32'(100 * (i + 1)));
        apply_and_check("R3 tor chain");
        // R3 TOR with self 0 wraps end to all ones
        set_entry(0, 8'h08, 32'h0);
        apply_and_check("R3 tor zero");

        // R4 inverted TOR collapses
        set_entry(2, 8'h00, 32'h0000_9000);
        set_entry(3, 8'h08, 32'h0000_1000);
        apply_and_check("R4 tor inverted");
        check("R4 lo3", 64'(lo[3*BW +: BW]), 64'd0);
        check("R4 hi3", 64'(hi[3*BW +: BW]), 64'd0);

        // R5 NA4 incl top
        set_entry(4, 8'h10, 32'hFFFF_FFFF);
        set_entry(5, 8'h10, 32'h0000_0000);
        apply_and_check("R5 na4");

        // R6 NAPOT corner sizes
        set_entry(0, 8'h18, 32'h0000_1000);
        set_entry(1, 8'h18, 32'h0000_1003);
        set_entry(6, 8'h18, 32'hFFFF_FFFF);
        set_entry(7, 8'h18, 32'h7FFF_FFFF);
        apply_and_check("R6 napot");
        check("R6 full lo", 64'(lo[6*BW +: BW]), 64'd0);
        check("R6 full hi", 64'(hi[6*BW +: BW]), 64'h3_FFFF_FFFF);

        // R8 other cfg bits flipped: outputs unchanged
        lo_keep = lo; hi_keep = hi; cnt_keep = count;
        for (int i = 0; i < N; i++) cfg[i*8 +: 8] = cfg[i*8 +: 8] ^ 8'hE7;
        apply_and_check("R8 ignore bits");
        check("R8 lo same", 64'(lo == lo_keep), 64'd1);
        check("R8 hi same", 64'(hi == hi_keep), 64'd1);
        check("R8 count same", 64'(count), 64'(cnt_keep));

        // R9 latency: change input, output still old just before edge
        lo_keep = lo;
        @(negedge clk);
        set_entry(0, 8'h10, 32'h0000_0040);
        #1;
        check("R9 hold", 64'(lo[0 +: BW]), 64'(lo_keep[0 +: BW]));
        @(posedge clk); #5;
        check("R9 update", 64'(lo[0 +: BW]), 64'h100);

        // Random mix R2..R7
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) begin
                logic [AW-1:0] a;
                int k;
                a = $urandom;
                if (($urandom % 3) == 0) a = a & 32'h0000_0FFF;
                if (($urandom % 2) == 0) begin
                    k = $urandom % 33;
                    if (k == 32) a = '1;
                    else a = (a & ~((AW'(1) << (k + 1)) - AW'(1))) | ((AW'(1) << k) - AW'(1));
                end
                set_entry(i, 8'($urandom), a);
            end
            apply_and_check("R2-R7 random");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule